// File: doc/BRIEF.md
# Pseudo-Random Logic Self-Test Controller

This block runs a built-in self-test on a combinational circuit that sits outside it. In normal operation the circuit's inputs come straight from their functional sources. When a test is started, a select flips those inputs over to a pseudo-random pattern source, and the circuit's responses are folded into a signature register on every cycle. After a fixed number of patterns, the signature is compared once with a golden value supplied on an input. A pass flag then reports whether the two matched.

The block is meant to be started by a single pulse after reset, so that correct operation can be checked at every power-on. The result stays visible until the next start pulse. The pattern source is a 16-bit maximal-length Galois LFSR. The signature register is a 16-bit multiple-input shift register built on the same polynomial.

Top module: `logic_selftest`

## Requirements
- R1: While reset is asserted and after its release, `testDone`, `testOkay` and `testMode` are low and `cutIn` equals `funcIn`.
- R2: Whenever `testMode` is low, `cutIn` equals `funcIn` in the same cycle.
- R3: A `start` pulse sampled while idle or finished raises `testMode` for exactly 1024 cycles, starting with the next cycle. During those cycles `cutIn` carries the LFSR sequence. The sequence begins at 16'hACE1, and each step shifts right by one and XORs 16'hB400 when the bit shifted out was 1. The LFSR value is never zero.
- R4: The signature is cleared to zero by the start pulse. In each test cycle it becomes its own Galois step (same rule as R3), XORed with `cutOut`.
- R5: `testDone` rises exactly one cycle after `testMode` falls.
- R6: When `testDone` is high, `testOkay` is 1 exactly when the final signature equals `goldenSig`.
- R7: `testOkay` is never high while `testDone` is low.
- R8: `testDone` and `testOkay` hold their values until a `start` pulse is sampled. That pulse drops `testDone` in the next cycle and begins a new test.
- R9: A `start` pulse during a running test has no effect on the pattern sequence, the run length or the result.
- R10: `funcIn` has no effect on the patterns or the signature while `testMode` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a test |
| funcIn | input | 16 | Functional source for the circuit inputs |
| cutOut | input | 16 | Responses of the circuit under test |
| goldenSig | input | 16 | Expected final signature |
| cutIn | output | 16 | Drive to the circuit inputs (functional or pattern) |
| testMode | output | 1 | High while patterns are applied |
| testDone | output | 1 | Test finished, result valid |
| testOkay | output | 1 | Signature matched the golden value |

## Verification
The idle path is tried with random functional words to show that the mux is transparent outside a test. Full runs are made against a modelled circuit, with random words on `funcIn` throughout. Every pattern is compared with an independent LFSR model, which separates a wrong seed, a wrong polynomial or a leaking functional input. A run with the correct golden value and a run with a deliberately wrong one tell a working compare apart from a stuck flag. A stray start pulse in the middle of a run, a hold period and a restart from the finished state check the control timing.

// File: rtl/selftest_pkg.sv
package selftest_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_RUN     = 2'd1,
    ST_COMPARE = 2'd2,
    ST_DONE    = 2'd3
  } phase_e;

  typedef struct packed {
    logic init;
    logic step;
    logic capture;
  } strobe_t;

endpackage

// File: rtl/selftest_datapath.sv
module selftest_datapath
  import selftest_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter logic [WIDTH-1:0] POLY_MASK = 16'hB400,
  parameter logic [WIDTH-1:0] SEED = 16'hACE1
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          ctl,
  input  logic [WIDTH-1:0] cutOut,
  input  logic [WIDTH-1:0] goldenSig,
  output logic [WIDTH-1:0] pattern,
  output logic             okayFlag
);

  function automatic logic [WIDTH-1:0] galoisStep(input logic [WIDTH-1:0] s);
    logic [WIDTH-1:0] n;
    n = s >> 1;
    if (s[0]) n = n ^ POLY_MASK;
    return n;
  endfunction

  logic [WIDTH-1:0] lfsrQ;
  logic [WIDTH-1:0] sigQ;
  logic             okayQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lfsrQ <= SEED;
      sigQ  <= '0;
      okayQ <= 1'b0;
    end else begin
      if (ctl.init) begin
        lfsrQ <= SEED;
        sigQ  <= '0;
        okayQ <= 1'b0;
      end else if (ctl.step) begin
        lfsrQ <= galoisStep(lfsrQ);
        sigQ  <= galoisStep(sigQ) ^ cutOut;
      end else if (ctl.capture) begin
        okayQ <= (sigQ == goldenSig);
      end
    end
  end

  assign pattern  = lfsrQ;
  assign okayFlag = okayQ;

  a_r3_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    lfsrQ != '0);

  a_r4_sig_cleared: assert property (@(posedge clk) disable iff (!rstN)
    ctl.init |=> (sigQ == '0 && lfsrQ == SEED));

  a_r3_lfsr_advances: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.step && !ctl.init) |=> lfsrQ != $past(lfsrQ));

endmodule

// File: rtl/selftest_control.sv
module selftest_control
  import selftest_pkg::*;
#(
  parameter int PATTERNS = 1024
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  output strobe_t ctl,
  output logic    testMode,
  output logic    testDone
);

  localparam int CW = (PATTERNS > 1) ? $clog2(PATTERNS) : 1;
  localparam logic [CW-1:0] LAST = CW'(PATTERNS - 1);

  phase_e        stQ;
  phase_e        stD;
  logic [CW-1:0] cntQ;

  always_comb begin
    stD = stQ;
    ctl = '0;
    unique case (stQ)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          ctl.init = 1'b1;
          stD      = ST_RUN;
        end
      end
      ST_RUN: begin
        ctl.step = 1'b1;
        if (cntQ == LAST) stD = ST_COMPARE;
      end
      ST_COMPARE: begin
        ctl.capture = 1'b1;
        stD         = ST_DONE;
      end
      default: stD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stQ  <= ST_IDLE;
      cntQ <= '0;
    end else begin
      stQ <= stD;
      if (ctl.init) cntQ <= '0;
      else if (ctl.step) cntQ <= cntQ + 1'b1;
    end
  end

  assign testMode = (stQ == ST_RUN);
  assign testDone = (stQ == ST_DONE);

  a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (stQ == ST_RUN && cntQ != LAST) |=> stQ == ST_RUN);

  a_r8_done_hold: assert property (@(posedge clk) disable iff (!rstN)
    (testDone && !start) |=> testDone);

  a_r5_done_after_compare: assert property (@(posedge clk) disable iff (!rstN)
    $rose(testDone) |-> $past(stQ) == ST_COMPARE);

  a_r3_run_leaves_after_last: assert property (@(posedge clk) disable iff (!rstN)
    (testMode && cntQ == LAST) |=> !testMode);

endmodule

// File: rtl/logic_selftest.sv
module logic_selftest
  import selftest_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int PATTERNS = 1024,
  parameter logic [WIDTH-1:0] POLY_MASK = 16'hB400,
  parameter logic [WIDTH-1:0] SEED = 16'hACE1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [WIDTH-1:0] funcIn,
  input  logic [WIDTH-1:0] cutOut,
  input  logic [WIDTH-1:0] goldenSig,
  output logic [WIDTH-1:0] cutIn,
  output logic             testMode,
  output logic             testDone,
  output logic             testOkay
);

  strobe_t          ctl;
  logic [WIDTH-1:0] pattern;

  selftest_control #(.PATTERNS(PATTERNS)) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start),
    .ctl(ctl), .testMode(testMode), .testDone(testDone)
  );

  selftest_datapath #(.WIDTH(WIDTH), .POLY_MASK(POLY_MASK), .SEED(SEED)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .cutOut(cutOut),
    .goldenSig(goldenSig), .pattern(pattern), .okayFlag(testOkay)
  );

  assign cutIn = testMode ? pattern : funcIn;

  a_r7_okay_needs_done: assert property (@(posedge clk) disable iff (!rstN)
    testOkay |-> testDone);

endmodule

// File: tb/logic_selftest_tb.sv
`timescale 1ns/1ps
module logic_selftest_tb_top;

  localparam int N = 1024;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [15:0] funcIn = '0;
  logic [15:0] goldenSig = '0;
  logic [15:0] cutIn;
  logic [15:0] cutOut;
  logic        testMode, testDone, testOkay;

  int compared = 0;
  int mismatched = 0;

  always #2.5 clk = ~clk;

  function automatic logic [15:0] galois(input logic [15:0] s);
    return s[0] ? ((s >> 1) ^ 16'hB400) : (s >> 1);
  endfunction

  function automatic logic [15:0] cutModel(input logic [15:0] x);
    return {x[12:0], x[15:13]} ^ (x + 16'h3C5A);
  endfunction

  function automatic logic [15:0] expectedSig();
    logic [15:0] l = 16'hACE1;
    logic [15:0] s = '0;
    for (int k = 0; k < N; k++) begin
      s = galois(s) ^ cutModel(l);
      l = galois(l);
    end
    return s;
  endfunction

  assign cutOut = cutModel(cutIn);

  logic_selftest dut_i (
    .clk(clk), .rstN(rstN), .start(start), .funcIn(funcIn),
    .cutOut(cutOut), .goldenSig(goldenSig), .cutIn(cutIn),
    .testMode(testMode), .testDone(testDone), .testOkay(testOkay)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic runTest(input logic [15:0] golden, input bit expOk, input int strayAt);
    logic [15:0] l = 16'hACE1;
    int patFails = 0;
    goldenSig = golden;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int k = 0; k < N; k++) begin
      if (testMode !== 1'b1 || cutIn !== l) patFails++;
      l = galois(l);
      funcIn = 16'($urandom);
      start = (k == strayAt);
      @(negedge clk);
    end
    start = 1'b0;
    check("R3/R10 pattern sequence errors", patFails, 0);
    check("R3 testMode low after 1024", testMode, 1'b0);
    check("R5 done not yet", testDone, 1'b0);
    check("R2 passthrough at compare", cutIn, funcIn);
    @(negedge clk);
    check("R5 done one cycle after testMode", testDone, 1'b1);
    check("R6/R9 okay result", testOkay, expOk);
  endtask

  initial begin
    #1000000;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [15:0] gold;
    void'($urandom(32'd1234));
    gold = expectedSig();
    funcIn = 16'h1234;
    #1;
    check("R1 done in reset", testDone, 1'b0);
    check("R1 okay in reset", testOkay, 1'b0);
    check("R1 mode in reset", testMode, 1'b0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 cutIn after reset", cutIn, funcIn);
    for (int i = 0; i < 6; i++) begin
      funcIn = 16'($urandom);
      #1;
      check("R2 idle passthrough", cutIn, funcIn);
      @(negedge clk);
    end
    check("R7 okay low when not done", testOkay, 1'b0);
    runTest(gold, 1'b1, 300);
    for (int i = 0; i < 5; i++) begin
      funcIn = 16'($urandom);
      @(negedge clk);
      check("R8 done holds", testDone, 1'b1);
      check("R8 okay holds", testOkay, 1'b1);
      check("R2 passthrough in done", cutIn, funcIn);
    end
    runTest(gold ^ 16'h0001, 1'b0, -1);
    check("R7 okay low with done high after mismatch", testOkay, 1'b0);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    check("R8 restart drops done", testDone, 1'b0);
    check("R4 first pattern after restart", cutIn, 16'hACE1);
    rstN = 1'b0;
    #1;
    rstN = 1'b1;
    runTest(gold, 1'b1, 5);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule